// File: doc/BRIEF.md
# Event Timestamping and Counting Unit

This block keeps a free-running 48-bit time base that advances once per system clock (25 ns per step at 40 MHz) and stamps selected events with it. The events are a rising edge of an asynchronous trigger line, the start and stop commands on a 16-bit command word stream, and both edges of an asynchronous busy line. Each stamped event becomes a typed record in a small FIFO. The FIFO drains through a valid/ready stream output.

The unit also counts triggers and readout cycles. A software enable gates record generation, so a noisy trigger line cannot flood the output. A flush input empties the FIFO. When an event is lost because the FIFO is full, or because another event won the same cycle, a sticky overflow flag is raised. The flag stays set until a flush or a reset.

Top module: `evts_stamp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the time base, both counters, the overflow flag and the FIFO are cleared. After that edge `out_valid` is 0 and `trig_count`, `ro_count` and `overflow` read 0.
- R2: The time base adds one on every clock edge with `rst` low, and wraps modulo 2^48. A record's `out_time` is the time base value held during the cycle in which its event reaches the write side of the FIFO.
- R3: A rising transition of `trig_in` first sampled at edge n reaches the write side in the cycle after edge n+1. Its stamp is therefore the time value held before edge n plus two. `trig_count` adds one for every synchronized rising edge, whether `stamp_en` is high or low. A trigger record has type 0, and its `out_count` is the trigger count including that trigger.
- R4: `cmd_valid` high with `cmd_word` = 0xE311 writes a type-1 record, and 0xE313 writes a type-2 record. Each is stamped with the time of the cycle in which the command is presented, and is visible after that edge. Any other word writes nothing. Non-trigger records carry `out_count` = 0.
- R5: `busy_in` rising and falling edges write records of type 3 and type 4. They have the same synchronizer latency and stamping as the trigger.
- R6: `ro_count` adds one at each clock edge where `ro_pulse` is high.
- R7: While `stamp_en` is low, no record is written and `overflow` does not change. The counters still count.
- R8: `flush` high at an edge empties the FIFO, clears `overflow`, and discards any event of that cycle.
- R9: The FIFO holds DEPTH records (8 by default). An event that finds it full at the start of the cycle is dropped and sets `overflow`. `overflow` stays set until a flush or a reset.
- R10: When several events arrive in the same cycle, the one with the lowest type code is written: trigger first, then start, stop, busy rise, busy fall. The others are dropped and `overflow` is set.
- R11: Records leave in arrival order. A record pops at an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the record on the output holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stamp_en | input | 1 | Enables record generation |
| flush | input | 1 | Empties the FIFO and clears overflow |
| trig_in | input | 1 | Asynchronous trigger line |
| busy_in | input | 1 | Asynchronous busy line |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command word |
| ro_pulse | input | 1 | One count per cycle high (readout cycle) |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts record |
| out_type | output | 3 | Event type code |
| out_time | output | 48 | Timestamp |
| out_count | output | 32 | Trigger count for trigger records, else 0 |
| trig_count | output | 32 | Triggers seen |
| ro_count | output | 32 | Readout cycles seen |
| overflow | output | 1 | Sticky lost-event flag |

## Verification
A command shows up at the output after the same edge that samples it. A trigger or busy edge shows up three edges after the line first changes: two synchronizer stages, then the FIFO write. The counters update at the edge that sees the event. The bench reproduces these delays in a behavioural model that is stepped on each rising edge. The model compares the output, the counters and the flag on every falling edge, so each result is checked in exactly the cycle it is due. Directed checks on top of the model count the same number of falling edges from the stimulus before they sample the output.

// File: rtl/evts_pkg.sv
package evts_pkg;
  localparam int TYPE_W = 3;
  localparam int NUM_EV = 5;
  typedef enum logic [TYPE_W-1:0] {
    EV_TRIG     = 3'd0,
    EV_ACQ_ON   = 3'd1,
    EV_ACQ_OFF  = 3'd2,
    EV_BUSY_UP  = 3'd3,
    EV_BUSY_DN  = 3'd4
  } ev_kind_e;
endpackage

// File: rtl/evts_sync2.sv
module evts_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= din[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign lvl[g]   = sync_q;
    assign lvl_d[g] = prev_q;
  end
endmodule

// File: rtl/evts_pick.sv
module evts_pick
  import evts_pkg::*;
#(
  parameter int N = NUM_EV
) (
  input  logic [N-1:0]      req,
  output logic              any,
  output logic              multi,
  output logic [TYPE_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = TYPE_W'(i);
    end
  end
  assign any   = |req;
  assign multi = ($countones(req) > 1);
endmodule

// File: rtl/evts_fifo.sv
module evts_fifo #(
  parameter int DW    = 83,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign full  = (cnt == CW'(DEPTH));
  assign valid = (cnt != '0);
  assign push  = wr_req && !full && !flush;
  assign pop   = valid && rd_ready && !flush;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign rd_data = mem[rd_ptr];

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !rd_ready && !flush) |=> (valid && $stable(rd_data))); // R11
endmodule

// File: rtl/evts_stamp_unit.sv
module evts_stamp_unit
  import evts_pkg::*;
#(
  parameter int              TIME_W    = 48,
  parameter int              CNT_W     = 32,
  parameter int              DEPTH     = 8,
  parameter int              CMD_W     = 16,
  parameter logic [CMD_W-1:0] CMD_START = 16'hE311,
  parameter logic [CMD_W-1:0] CMD_STOP  = 16'hE313
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stamp_en,
  input  logic              flush,
  input  logic              trig_in,
  input  logic              busy_in,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              ro_pulse,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TYPE_W-1:0] out_type,
  output logic [TIME_W-1:0] out_time,
  output logic [CNT_W-1:0]  out_count,
  output logic [CNT_W-1:0]  trig_count,
  output logic [CNT_W-1:0]  ro_count,
  output logic              overflow
);
  localparam int REC_W = TYPE_W + TIME_W + CNT_W;

  logic [TIME_W-1:0] now_q;
  logic [CNT_W-1:0]  trig_cnt_q, ro_cnt_q;
  logic              ovf_q;
  logic [1:0]        lvl, lvl_d;
  logic              trig_rise, busy_rise, busy_fall, cmd_on, cmd_off;
  logic [NUM_EV-1:0] req;
  logic              ev_any, ev_multi, fifo_full, wr_req;
  logic [TYPE_W-1:0] ev_idx;
  logic [CNT_W-1:0]  cnt_field;
  logic [REC_W-1:0]  rec_in, rec_out;

  // time base
  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + 1'b1;
  end

  evts_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   ({busy_in, trig_in}),
    .lvl   (lvl),
    .lvl_d (lvl_d)
  );

  assign trig_rise = lvl[0] & ~lvl_d[0];
  assign busy_rise = lvl[1] & ~lvl_d[1];
  assign busy_fall = ~lvl[1] & lvl_d[1];
  assign cmd_on    = cmd_valid && (cmd_word == CMD_START);
  assign cmd_off   = cmd_valid && (cmd_word == CMD_STOP);

  always_comb begin
    req = '0;
    req[EV_TRIG]    = trig_rise;
    req[EV_ACQ_ON]  = cmd_on;
    req[EV_ACQ_OFF] = cmd_off;
    req[EV_BUSY_UP] = busy_rise;
    req[EV_BUSY_DN] = busy_fall;
  end

  evts_pick #(.N(NUM_EV)) u_pick (
    .req   (req),
    .any   (ev_any),
    .multi (ev_multi),
    .idx   (ev_idx)
  );

  // counters
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_cnt_q <= '0;
      ro_cnt_q   <= '0;
    end else begin
      if (trig_rise) trig_cnt_q <= trig_cnt_q + 1'b1;
      if (ro_pulse)  ro_cnt_q   <= ro_cnt_q + 1'b1;
    end
  end

  assign cnt_field = (ev_idx == EV_TRIG) ? trig_cnt_q + 1'b1 : '0;
  assign rec_in    = {ev_idx, now_q, cnt_field};
  assign wr_req    = stamp_en && ev_any;

  evts_fifo #(.DW(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .wr_req   (wr_req),
    .wr_data  (rec_in),
    .full     (fifo_full),
    .valid    (out_valid),
    .rd_ready (out_ready),
    .rd_data  (rec_out)
  );

  // sticky lost-event flag
  always_ff @(posedge clk) begin
    if (rst || flush)                      ovf_q <= 1'b0;
    else if (wr_req && (fifo_full || ev_multi)) ovf_q <= 1'b1;
  end

  assign out_type   = rec_out[REC_W-1 -: TYPE_W];
  assign out_time   = rec_out[CNT_W +: TIME_W];
  assign out_count  = rec_out[CNT_W-1:0];
  assign trig_count = trig_cnt_q;
  assign ro_count   = ro_cnt_q;
  assign overflow   = ovf_q;

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (now_q == TIME_W'($past(now_q) + 1'b1))); // R2
  AST_TRIG_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((trig_count == $past(trig_count)) ||
                     (trig_count == CNT_W'($past(trig_count) + 1'b1)))); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!stamp_en && !out_valid) |=> !out_valid); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && !overflow)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow && !flush) |=> overflow); // R9
endmodule

// File: tb/sim_evts_stamp_unit.sv
module sim_evts_stamp_unit;
  localparam int DEPTH = 8;

  typedef struct packed {
    logic [2:0]  ty;
    logic [47:0] tm;
    logic [31:0] ct;
  } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stamp_en = 1'b0, flush = 1'b0, trig_in = 1'b0, busy_in = 1'b0;
  logic cmd_valid = 1'b0, ro_pulse = 1'b0, out_ready = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        out_valid, overflow;
  logic [2:0]  out_type;
  logic [47:0] out_time;
  logic [31:0] out_count, trig_count, ro_count;

  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  evts_stamp_unit #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .stamp_en(stamp_en), .flush(flush),
    .trig_in(trig_in), .busy_in(busy_in), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .ro_pulse(ro_pulse), .out_valid(out_valid),
    .out_ready(out_ready), .out_type(out_type), .out_time(out_time),
    .out_count(out_count), .trig_count(trig_count), .ro_count(ro_count),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  rec_t        mq[$];
  logic [47:0] tm;
  logic [31:0] mtc, mrc;
  logic        movf;
  logic        t1, t2, t3, b1, b2, b3;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); tm = '0; mtc = '0; mrc = '0; movf = 1'b0;
      t1 = 0; t2 = 0; t3 = 0; b1 = 0; b2 = 0; b3 = 0;
    end else begin
      logic tr, br, bf, cs, cp;
      int   n, sz;
      rec_t r;
      tr = t2 & ~t3;
      br = b2 & ~b3;
      bf = ~b2 & b3;
      cs = cmd_valid && cmd_word == 16'hE311;
      cp = cmd_valid && cmd_word == 16'hE313;
      if (tr) mtc = mtc + 1;
      if (ro_pulse) mrc = mrc + 1;
      if (flush) begin
        mq.delete(); movf = 1'b0;
      end else begin
        sz = mq.size();
        n = int'(tr) + int'(cs) + int'(cp) + int'(br) + int'(bf);
        if (sz > 0 && out_ready) void'(mq.pop_front());
        if (stamp_en && n > 0) begin
          if (n > 1) movf = 1'b1;
          if (sz < DEPTH) begin
            r.ty = tr ? 3'd0 : cs ? 3'd1 : cp ? 3'd2 : br ? 3'd3 : 3'd4;
            r.tm = tm;
            r.ct = tr ? mtc : 32'd0;
            mq.push_back(r);
          end else movf = 1'b1;
        end
      end
      t3 = t2; t2 = t1; t1 = trig_in;
      b3 = b2; b2 = b1; b1 = busy_in;
      tm = tm + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == (mq.size() > 0), "R11 valid", 64'(out_valid), 64'(mq.size() > 0));
      if (out_valid && mq.size() > 0) begin
        chk(out_type == mq[0].ty, "R10 type", 64'(out_type), 64'(mq[0].ty));
        chk(out_time == mq[0].tm, "R2 time", 64'(out_time), 64'(mq[0].tm));
        chk(out_count == mq[0].ct, "R3 count field", 64'(out_count), 64'(mq[0].ct));
      end
      chk(trig_count == mtc, "R3 trig_count", 64'(trig_count), 64'(mtc));
      chk(ro_count == mrc, "R6 ro_count", 64'(ro_count), 64'(mrc));
      chk(overflow == movf, "R9 overflow", 64'(overflow), 64'(movf));
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- directed stimulus ----------------
  initial begin
    logic [47:0] t0;
    logic [31:0] tc0;
    int drained;
    idle(4);
    chk(out_valid == 0, "R1 valid", 64'(out_valid), 0);
    chk(trig_count == 0, "R1 trig_count", 64'(trig_count), 0);
    chk(ro_count == 0, "R1 ro_count", 64'(ro_count), 0);
    chk(overflow == 0, "R1 overflow", 64'(overflow), 0);
    rst = 1'b0;
    stamp_en = 1'b1; out_ready = 1'b1;
    idle(3);

    // R3 trigger record
    t0 = tm; trig_in = 1'b1;
    idle(1); trig_in = 1'b0;
    idle(2);
    chk(out_valid && out_type == 3'd0, "R3 trig type", 64'(out_type), 0);
    chk(out_time == t0 + 2, "R3 trig stamp", 64'(out_time), 64'(t0 + 2));
    chk(out_count == 32'd1, "R3 trig count field", 64'(out_count), 1);
    idle(3);

    // R4 start/stop commands
    out_ready = 1'b0;
    t0 = tm; cmd_valid = 1'b1; cmd_word = 16'hE311;
    idle(1); cmd_valid = 1'b0;
    chk(out_valid && out_type == 3'd1, "R4 start type", 64'(out_type), 1);
    chk(out_time == t0, "R4 start stamp", 64'(out_time), 64'(t0));
    chk(out_count == 0, "R4 count zero", 64'(out_count), 0);
    out_ready = 1'b1; idle(2);
    cmd_valid = 1'b1; cmd_word = 16'h1234;
    idle(1); cmd_valid = 1'b0;
    chk(out_valid == 0, "R4 other word ignored", 64'(out_valid), 0);
    t0 = tm; cmd_valid = 1'b1; cmd_word = 16'hE313;
    idle(1); cmd_valid = 1'b0;
    chk(out_type == 3'd2 && out_time == t0, "R4 stop record", 64'(out_type), 2);
    idle(2);

    // R5 busy edges
    t0 = tm; busy_in = 1'b1;
    idle(3);
    chk(out_type == 3'd3 && out_time == t0 + 2, "R5 busy rise", 64'(out_time), 64'(t0 + 2));
    idle(2);
    t0 = tm; busy_in = 1'b0;
    idle(3);
    chk(out_type == 3'd4 && out_time == t0 + 2, "R5 busy fall", 64'(out_time), 64'(t0 + 2));
    idle(2);

    // R6 readout counting
    tc0 = ro_count;
    ro_pulse = 1'b1; idle(3); ro_pulse = 1'b0;
    chk(ro_count == tc0 + 3, "R6 three pulses", 64'(ro_count), 64'(tc0 + 3));

    // R7 disabled
    stamp_en = 1'b0; tc0 = trig_count;
    trig_in = 1'b1; idle(1); trig_in = 1'b0;
    cmd_valid = 1'b1; cmd_word = 16'hE311; idle(1); cmd_valid = 1'b0;
    idle(4);
    chk(out_valid == 0, "R7 no record when disabled", 64'(out_valid), 0);
    chk(trig_count == tc0 + 1, "R7 still counts", 64'(trig_count), 64'(tc0 + 1));
    stamp_en = 1'b1;

    // R9 full FIFO
    out_ready = 1'b0;
    cmd_valid = 1'b1;
    for (int i = 0; i < DEPTH + 3; i++) begin
      cmd_word = (i % 2 == 0) ? 16'hE311 : 16'hE313;
      idle(1);
    end
    cmd_valid = 1'b0;
    chk(overflow == 1, "R9 overflow set when full", 64'(overflow), 1);
    out_ready = 1'b1; drained = 0;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      if (out_valid) drained++;
      idle(1);
    end
    chk(drained == DEPTH, "R9 depth kept", 64'(drained), 64'(DEPTH));
    chk(overflow == 1, "R9 sticky", 64'(overflow), 1);

    // R8 flush
    out_ready = 1'b0;
    cmd_valid = 1'b1; cmd_word = 16'hE311; idle(3);
    flush = 1'b1; idle(1); flush = 1'b0; cmd_valid = 1'b0;
    chk(out_valid == 0, "R8 emptied", 64'(out_valid), 0);
    chk(overflow == 0, "R8 overflow cleared", 64'(overflow), 0);

    // R10 collision: trigger and stop command in the same cycle
    t0 = tm; trig_in = 1'b1;
    idle(1); trig_in = 1'b0;
    idle(1); cmd_valid = 1'b1; cmd_word = 16'hE313;
    idle(1); cmd_valid = 1'b0;
    chk(out_valid && out_type == 3'd0, "R10 trigger wins", 64'(out_type), 0);
    chk(out_time == t0 + 2, "R10 stamp", 64'(out_time), 64'(t0 + 2));
    chk(out_count == trig_count, "R10 count field", 64'(out_count), 64'(trig_count));
    chk(overflow == 1, "R10 loser flagged", 64'(overflow), 1);
    flush = 1'b1; idle(1); flush = 1'b0;

    // mixed traffic with stalls, checked by the model
    for (int i = 0; i < 400; i++) begin
      trig_in   = ($urandom % 3) == 0;
      busy_in   = ($urandom % 5) == 0 ? ~busy_in : busy_in;
      cmd_valid = ($urandom % 4) == 0;
      cmd_word  = ($urandom % 2) ? 16'hE311 : (($urandom % 2) ? 16'hE313 : 16'h0000);
      ro_pulse  = ($urandom % 6) == 0;
      out_ready = ($urandom % 3) != 0;
      stamp_en  = ($urandom % 20) != 0;
      flush     = ($urandom % 60) == 0;
      idle(1);
    end
    trig_in = 0; cmd_valid = 0; ro_pulse = 0; flush = 0; out_ready = 1;
    idle(20);
    chk(out_valid == 0, "R11 drained", 64'(out_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule